// File: doc/BRIEF.md
# Dual-Channel Shadowed Configuration Register Bank

This block holds the byte-wide configuration space of a two-channel converter behind a plain write/read bus. Each address falls into one of six kinds: direct global registers, which take effect on the write edge; the channel-select register; per-channel (local) shadowed registers; shared (global) shadowed registers; the transfer command; and unsupported holes. Every shadowed address has two copies. Bus writes land in the pending (shadow) copy. The live (active) copy, which drives the outputs, changes only when a transfer is committed.

The channel-select register decides which channel copies a local write reaches. Setting both select bits writes both channels with a single access. A local read returns channel A's copy whenever the A bit is set. A small state machine, with the states `XF_IDLE` and `XF_ARMED`, sequences the transfer. A write that sets bit 0 of address 0xFF takes `XF_IDLE` to `XF_ARMED`. From `XF_ARMED` the machine always returns to `XF_IDLE` on the next edge, and on that same edge every live copy loads its shadow value at once. A second request made while the machine is in `XF_ARMED` is absorbed into the commit already under way.

Each channel's live configuration is presented as a flat vector. The byte for address n sits at bits [8n+7:8n]. Global and direct registers appear in both channel vectors.

Top module: `cfgbank_top`

## Requirements
- R1: After reset, address 0x05 reads 0x03, address 0x14 reads 0x05 and live 0x14 is 0x05 in both channels, address 0xFF reads 0x00, and every other address reads 0x00.
- R2: Address 0x05 is the channel-select register. Bit 0 selects channel A, bit 1 selects channel B, and bits 7:2 read as 0.
- R3: A write to a local address (0x08 to 0x20, or 0x3A) updates the shadow copy of every channel whose select bit is set. With both bits set, one write updates both copies.
- R4: A read of a local address returns channel A's copy when bit 0 of 0x05 is set, including when both bits are set. It returns channel B's copy when only bit 1 is set, and 0x00 when neither bit is set. A local write made with neither bit set has no effect.
- R5: The global shadowed addresses (0x40 to 0x42, 0x45 to 0x4C, 0x50 to 0x5A) and the direct addresses (0x00 to 0x02) are written and read the same way whatever 0x05 holds.
- R6: Writes to shadowed addresses leave both live vectors unchanged until a transfer commits.
- R7: A write with bit 0 set to 0xFF enters `XF_ARMED`. On the following clock edge every live copy loads its shadow value in the same cycle, and the machine returns to `XF_IDLE`.
- R8: 0xFF reads 0x01 only while the machine is in `XF_ARMED` and reads 0x00 otherwise. A write to 0xFF with bit 0 clear starts no transfer.
- R9: The direct registers 0x00 to 0x02 reach both live vectors on the edge of the write itself.
- R10: Unsupported addresses (for example 0x03, 0x21 to 0x39, 0x43) read 0x00, ignore writes and show 0x00 in the live vectors.
- R11: Reserved bits read as 0. The writable masks are 0x1F at 0x14, 0x0F at 0x18, 0x03 at 0x05 and 0x01 at 0xFF, and 0xFF everywhere else.
- R12: A read of a shadowed address returns the pending shadow value, not the live value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_addr | input | 8 | Byte address for read and write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational readback of bus_addr |
| live_a | output | 2048 | Channel A live configuration, byte n at [8n+7:8n] |
| live_b | output | 2048 | Channel B live configuration, byte n at [8n+7:8n] |

## Verification
The assertions assume that the bus issues at most one write per cycle, with a stable address and data around the clock edge. They also assume that reset is asserted long enough to load every default before the first access. The bench changes the bus only on falling edges and holds each write for exactly one rising edge. It never writes outside the state it then samples, so every expected value follows from the sequence of writes alone. Transfers are requested only from `XF_IDLE`, so each commit can be attributed to a single request.

// File: rtl/cfgbank_pkg.sv
package cfgbank_pkg;

    localparam int AW     = 8;
    localparam int DW     = 8;
    localparam int NCH    = 2;
    localparam int DEPTH  = 1 << AW;
    localparam int LIVE_W = DEPTH * DW;
    localparam int NDIR   = 3;

    typedef logic [AW-1:0] addr_t;
    typedef logic [DW-1:0] byte_t;

    typedef enum logic [0:0] {
        XF_IDLE  = 1'b0,
        XF_ARMED = 1'b1
    } xfer_state_e;

    typedef enum logic [2:0] {
        RK_NONE   = 3'd0,
        RK_DIRECT = 3'd1,
        RK_INDEX  = 3'd2,
        RK_LOCAL  = 3'd3,
        RK_GLOBAL = 3'd4,
        RK_XFER   = 3'd5
    } reg_kind_e;

    localparam addr_t SEL_ADDR  = 8'h05;
    localparam addr_t XFER_ADDR = 8'hFF;

    // Classify an address into its storage kind.
    function automatic reg_kind_e kind_of(addr_t a);
        int v;
        v = int'(a);
        if (v <= 2)                        return RK_DIRECT;
        if (a == SEL_ADDR)                 return RK_INDEX;
        if (a == XFER_ADDR)                return RK_XFER;
        if ((v >= 8 && v <= 32) || v == 58) return RK_LOCAL;
        if ((v >= 64 && v <= 66) || (v >= 69 && v <= 76) || (v >= 80 && v <= 90))
            return RK_GLOBAL;
        return RK_NONE;
    endfunction

    // Writable bits of each address; everything else reads as zero.
    function automatic byte_t mask_of(addr_t a);
        if (kind_of(a) == RK_NONE) return '0;
        if (a == SEL_ADDR)         return 8'h03;
        if (a == XFER_ADDR)        return 8'h01;
        if (a == 8'h14)            return 8'h1F;
        if (a == 8'h18)            return 8'h0F;
        return 8'hFF;
    endfunction

    // Reset value of each address.
    function automatic byte_t dflt_of(addr_t a);
        if (a == SEL_ADDR) return 8'h03;
        if (a == 8'h14)    return 8'h05;
        return 8'h00;
    endfunction

endpackage

// File: rtl/cfg_xfer_fsm.sv
module cfg_xfer_fsm
    import cfgbank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_req,
    output logic commit
);

    xfer_state_e st_q;
    xfer_state_e st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= XF_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            XF_IDLE:  st_d = xfer_req ? XF_ARMED : XF_IDLE;
            XF_ARMED: st_d = XF_IDLE;
            default:  st_d = XF_IDLE;
        endcase
    end

    always_comb begin
        commit = (st_q == XF_ARMED);
    end

    // R7: a request seen in XF_IDLE is committed on the next edge
    a_r7_arm_then_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_req && !commit) |=> commit);

    // R8: the transfer bit never stays set for two cycles
    a_r8_self_clear: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> !commit);

endmodule

// File: rtl/cfg_shadow_bank.sv
module cfg_shadow_bank
    import cfgbank_pkg::*;
#(
    parameter reg_kind_e KIND = RK_LOCAL
)
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  addr_t             wr_addr,
    input  byte_t             wr_data,
    input  logic              commit,
    input  addr_t             rd_addr,
    output byte_t             rd_shadow,
    output logic [LIVE_W-1:0] shadow_flat,
    output logic [LIVE_W-1:0] active_flat
);

    byte_t shadow_q [DEPTH];
    byte_t active_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                shadow_q[i] <= (kind_of(addr_t'(i)) == KIND) ? dflt_of(addr_t'(i)) : '0;
                active_q[i] <= (kind_of(addr_t'(i)) == KIND) ? dflt_of(addr_t'(i)) : '0;
            end
        end else begin
            if (commit) begin
                for (int i = 0; i < DEPTH; i++) begin
                    active_q[i] <= shadow_q[i];
                end
            end
            if (wr_en && (kind_of(wr_addr) == KIND)) begin
                shadow_q[wr_addr] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_shadow = shadow_q[rd_addr];
        for (int i = 0; i < DEPTH; i++) begin
            shadow_flat[i*DW +: DW] = shadow_q[i];
            active_flat[i*DW +: DW] = (kind_of(addr_t'(i)) == KIND) ? active_q[i] : '0;
        end
    end

    // R6: live copies hold whenever no commit is under way
    a_r6_live_holds: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(active_flat));

    // R7: a commit copies the whole pending image in one cycle
    a_r7_bulk_copy: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (active_flat == $past(shadow_flat)));

endmodule

// File: rtl/cfgbank_top.sv
module cfgbank_top
    import cfgbank_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [AW-1:0]     bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic [LIVE_W-1:0] live_a,
    output logic [LIVE_W-1:0] live_b
);

    reg_kind_e          acc_kind;
    byte_t              wr_masked;
    logic [NCH-1:0]     chan_sel;
    byte_t              dir_q [NDIR];
    logic [LIVE_W-1:0]  dir_flat;
    logic               xfer_req;
    logic               commit;
    logic [NCH-1:0]     loc_wr;
    byte_t              loc_rd   [NCH];
    logic [LIVE_W-1:0]  loc_sh   [NCH];
    logic [LIVE_W-1:0]  loc_act  [NCH];
    logic               glb_wr;
    byte_t              glb_rd;
    logic [LIVE_W-1:0]  glb_sh;
    logic [LIVE_W-1:0]  glb_act;

    always_comb begin
        acc_kind  = kind_of(bus_addr);
        wr_masked = bus_wdata & mask_of(bus_addr);
        xfer_req  = bus_wr && (acc_kind == RK_XFER) && bus_wdata[0];
        glb_wr    = bus_wr && (acc_kind == RK_GLOBAL);
        for (int c = 0; c < NCH; c++) begin
            loc_wr[c] = bus_wr && (acc_kind == RK_LOCAL) && chan_sel[c];
        end
    end

    // Channel-select and direct (unshadowed) global registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chan_sel <= dflt_of(SEL_ADDR)[NCH-1:0];
            for (int i = 0; i < NDIR; i++) begin
                dir_q[i] <= dflt_of(addr_t'(i));
            end
        end else if (bus_wr) begin
            if (acc_kind == RK_INDEX) begin
                chan_sel <= wr_masked[NCH-1:0];
            end
            if (acc_kind == RK_DIRECT) begin
                dir_q[bus_addr[1:0]] <= wr_masked;
            end
        end
    end

    always_comb begin
        dir_flat = '0;
        for (int i = 0; i < NDIR; i++) begin
            dir_flat[i*DW +: DW] = dir_q[i];
        end
    end

    cfg_xfer_fsm u_xfer (
        .clk      (clk),
        .rst_n    (rst_n),
        .xfer_req (xfer_req),
        .commit   (commit)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        cfg_shadow_bank #(.KIND(RK_LOCAL)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .wr_en       (loc_wr[c]),
            .wr_addr     (bus_addr),
            .wr_data     (wr_masked),
            .commit      (commit),
            .rd_addr     (bus_addr),
            .rd_shadow   (loc_rd[c]),
            .shadow_flat (loc_sh[c]),
            .active_flat (loc_act[c])
        );
    end

    cfg_shadow_bank #(.KIND(RK_GLOBAL)) u_glb (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (glb_wr),
        .wr_addr     (bus_addr),
        .wr_data     (wr_masked),
        .commit      (commit),
        .rd_addr     (bus_addr),
        .rd_shadow   (glb_rd),
        .shadow_flat (glb_sh),
        .active_flat (glb_act)
    );

    // Readback follows the address kind and, for local registers, the select bits.
    always_comb begin
        bus_rdata = '0;
        unique case (acc_kind)
            RK_NONE:   bus_rdata = '0;
            RK_DIRECT: bus_rdata = dir_q[bus_addr[1:0]];
            RK_INDEX:  bus_rdata = {{(DW-NCH){1'b0}}, chan_sel};
            RK_XFER:   bus_rdata = {{(DW-1){1'b0}}, commit};
            RK_GLOBAL: bus_rdata = glb_rd;
            RK_LOCAL:  bus_rdata = chan_sel[0] ? loc_rd[0] :
                                   chan_sel[1] ? loc_rd[1] : '0;
            default:   bus_rdata = '0;
        endcase
    end

    always_comb begin
        live_a = loc_act[0] | glb_act | dir_flat;
        live_b = loc_act[1] | glb_act | dir_flat;
    end

    // R3: a local write with both bits set leaves both pending copies equal
    a_r3_dual_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && acc_kind == RK_LOCAL && chan_sel == 2'b11) |=>
        (loc_sh[0][$past(bus_addr)*DW +: DW] == loc_sh[1][$past(bus_addr)*DW +: DW]));

    // R5: a global write lands regardless of the select register
    a_r5_global_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && acc_kind == RK_GLOBAL) |=>
        (glb_sh[$past(bus_addr)*DW +: DW] == $past(wr_masked)));

    // R4: a local write with no select bit leaves both pending copies alone
    a_r4_no_select: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && acc_kind == RK_LOCAL && chan_sel == 2'b00) |=>
        ($stable(loc_sh[0]) && $stable(loc_sh[1])));

    // R11: the select register never reads with reserved bits set
    a_r11_sel_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_kind == RK_INDEX) |-> (bus_rdata[DW-1:NCH] == '0));

endmodule

// File: tb/cfgbank_top_bench.sv
module cfgbank_top_bench;
    import cfgbank_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_wr = 1'b0;
    logic [AW-1:0]     bus_addr = '0;
    logic [DW-1:0]     bus_wdata = '0;
    logic [DW-1:0]     bus_rdata;
    logic [LIVE_W-1:0] live_a;
    logic [LIVE_W-1:0] live_b;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    cfgbank_top u_cfgbank_top (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .live_a    (live_a),
        .live_b    (live_b)
    );

    // op: 0 write, 1 read check, 2 live A check, 3 live B check
    localparam int NV = 31;
    localparam logic [29:0] VEC [NV] = '{
        {2'd0, 4'd11, 8'h14, 8'h3A, 8'h00},
        {2'd1, 4'd12, 8'h14, 8'h00, 8'h1A}, // R12 R11 pending value, masked
        {2'd2, 4'd6,  8'h14, 8'h00, 8'h05}, // R6 live A unchanged
        {2'd3, 4'd6,  8'h14, 8'h00, 8'h05}, // R6 live B unchanged
        {2'd0, 4'd2,  8'h05, 8'hFD, 8'h00},
        {2'd1, 4'd2,  8'h05, 8'h00, 8'h01}, // R2 reserved select bits dropped
        {2'd0, 4'd3,  8'h10, 8'h77, 8'h00},
        {2'd1, 4'd4,  8'h10, 8'h00, 8'h77}, // R4 A only
        {2'd0, 4'd2,  8'h05, 8'h02, 8'h00},
        {2'd1, 4'd3,  8'h10, 8'h00, 8'h00}, // R3 B untouched by A-only write
        {2'd0, 4'd3,  8'h10, 8'h66, 8'h00},
        {2'd1, 4'd4,  8'h10, 8'h00, 8'h66}, // R4 B only
        {2'd0, 4'd2,  8'h05, 8'h03, 8'h00},
        {2'd1, 4'd4,  8'h10, 8'h00, 8'h77}, // R4 both selected reads A
        {2'd0, 4'd3,  8'h3A, 8'h34, 8'h00},
        {2'd0, 4'd2,  8'h05, 8'h00, 8'h00},
        {2'd0, 4'd5,  8'h45, 8'hC3, 8'h00},
        {2'd1, 4'd5,  8'h45, 8'h00, 8'hC3}, // R5 global with no select
        {2'd1, 4'd4,  8'h10, 8'h00, 8'h00}, // R4 neither selected reads 0
        {2'd0, 4'd4,  8'h10, 8'h11, 8'h00},
        {2'd0, 4'd5,  8'h5A, 8'h12, 8'h00},
        {2'd0, 4'd2,  8'h05, 8'h03, 8'h00},
        {2'd1, 4'd4,  8'h10, 8'h00, 8'h77}, // R4 write with no select ignored
        {2'd0, 4'd9,  8'h01, 8'h5A, 8'h00},
        {2'd2, 4'd9,  8'h01, 8'h00, 8'h5A}, // R9 direct reaches A at once
        {2'd3, 4'd9,  8'h01, 8'h00, 8'h5A}, // R9 direct reaches B at once
        {2'd0, 4'd10, 8'h21, 8'hAA, 8'h00},
        {2'd1, 4'd10, 8'h21, 8'h00, 8'h00}, // R10 hole reads 0
        {2'd2, 4'd10, 8'h21, 8'h00, 8'h00}, // R10 hole live 0
        {2'd0, 4'd11, 8'h18, 8'hFF, 8'h00},
        {2'd1, 4'd11, 8'h18, 8'h00, 8'h0F}  // R11 mask at 0x18
    };

    task automatic report(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic chk_rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        report(req, bus_rdata, exp);
    endtask

    task automatic chk_live(input bit chb, input logic [7:0] a, input logic [7:0] exp, input string req);
        @(negedge clk);
        #1;
        report(req, chb ? live_b[a*DW +: DW] : live_a[a*DW +: DW], exp);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        chk_rd(8'h05, 8'h03, "R1 select default");
        chk_rd(8'h14, 8'h05, "R1 0x14 default");
        chk_rd(8'hFF, 8'h00, "R1 transfer bit clear");
        chk_rd(8'h10, 8'h00, "R1 local default");
        chk_live(1'b0, 8'h14, 8'h05, "R1 live A 0x14");
        chk_live(1'b1, 8'h14, 8'h05, "R1 live B 0x14");

        for (int i = 0; i < NV; i++) begin
            logic [1:0] op;
            logic [3:0] rq;
            logic [7:0] a, d, e;
            {op, rq, a, d, e} = VEC[i];
            case (op)
                2'd0: do_wr(a, d);
                2'd1: chk_rd(a, e, $sformatf("R%0d vector %0d", rq, i));
                2'd2: chk_live(1'b0, a, e, $sformatf("R%0d vector %0d", rq, i));
                default: chk_live(1'b1, a, e, $sformatf("R%0d vector %0d", rq, i));
            endcase
        end

        // R8 a write of 0 to 0xFF starts nothing
        do_wr(8'hFF, 8'h00);
        chk_rd(8'hFF, 8'h00, "R8 zero write no arm");
        chk_live(1'b0, 8'h10, 8'h00, "R8 no commit");

        // R7 transfer: armed for one cycle, then bulk commit
        do_wr(8'hFF, 8'h01);
        #1;
        report("R8 transfer bit set", bus_rdata, 8'h01);
        report("R7 live before commit", live_a[8'h10*DW +: DW], 8'h00);
        chk_rd(8'hFF, 8'h00, "R8 transfer bit self-clears");
        chk_live(1'b0, 8'h10, 8'h77, "R7 live A 0x10");
        chk_live(1'b1, 8'h10, 8'h66, "R7 live B 0x10");
        chk_live(1'b0, 8'h14, 8'h1A, "R7 live A 0x14");
        chk_live(1'b1, 8'h3A, 8'h34, "R7 live B 0x3A");
        chk_live(1'b1, 8'h45, 8'hC3, "R7 global in B");
        chk_live(1'b0, 8'h5A, 8'h12, "R7 global in A");
        chk_live(1'b1, 8'h18, 8'h0F, "R7 live B 0x18");

        // R12 pending differs from live after a new write
        do_wr(8'h10, 8'h21);
        chk_rd(8'h10, 8'h21, "R12 pending readback");
        chk_live(1'b0, 8'h10, 8'h77, "R6 live keeps old");

        // R1 reset again restores defaults
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        chk_rd(8'h10, 8'h00, "R1 local after reset");
        chk_rd(8'h05, 8'h03, "R1 select after reset");
        chk_live(1'b0, 8'h01, 8'h00, "R1 direct after reset");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual hung expected done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule